// File: doc/BRIEF.md
# Nearest-Rate Clock Divider Search Engine

This block picks the setting of a two-stage serial clock divider that lands closest to a wanted bus rate. The divider has a 4-bit linear stage M and a 3-bit power-of-two stage N. For a pair (M, N) the resulting rate is the core clock frequency divided by `(10 * (M + 1)) << N`, rounded down.

A start pulse captures the core frequency and the target frequency. The engine then walks all 128 pairs one after another. Each quotient comes from a shared bit-serial restoring divider, so the datapath has no combinational divide. When the walk is complete, the engine reports the best pair as a packed 7-bit word and raises a one-cycle done pulse. A core frequency of zero cannot yield a rate. In that case the engine ends at once with a failure flag and a zero word.

Top module: `baud_div_search`

## Requirements
- R1: The candidate rate for pair (M, N), with M in 0..15 and N in 0..7, is floor(core_hz_i / ((10*(M+1)) << N)).
- R2: The error of a candidate is the absolute difference between goal_hz_i and the candidate rate. The reported pair is one with the smallest error.
- R3: Scan order puts N in the outer loop and M in the inner loop (index N*16+M, rising). On equal error the earlier pair is kept, so a later pair replaces it only with a strictly smaller error.
- R4: param_o holds M in bits 6:3 and N in bits 2:0.
- R5: start_i sampled high while idle with core_hz_i nonzero has two effects. busy_o is high from the next cycle until the search ends. done_o then goes high for exactly one cycle, with busy_o low in that cycle.
- R6: start_i sampled high while idle with core_hz_i equal to zero has three effects. busy_o stays low, done_o is high in the next cycle, and in that cycle fail_o is 1 and param_o is 0.
- R7: start_i sampled while busy_o is high is ignored. The running search keeps its captured inputs, its result and its completion time.
- R8: param_o and fail_o change only in a cycle where done_o is high. After a search with nonzero core_hz_i, fail_o is 0.
- R9: done_o goes high on the clock edge 128*(32+2) = 4352 edges after the edge that samples start_i (128 candidates, each taking 34 cycles at FREQ_W = 32).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search; sampled only while idle |
| core_hz_i | input | 32 | Core clock frequency, captured at start |
| goal_hz_i | input | 32 | Wanted serial clock rate, captured at start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Set with done when the core frequency was zero |
| param_o | output | 7 | Best pair, M in bits 6:3, N in bits 2:0 |

## Verification
Two of the block's functions can coincide in one cycle: a running search can receive a new start request. That request may even carry a zero core frequency, which would otherwise end a search at once. The bench provokes this by pulsing start_i in the middle of a search with different frequencies, including a zero core frequency. It judges the outcome by three things at the ports: done_o must still arrive exactly on the nominal edge, fail_o must stay clear, and param_o must match the nearest pair for the inputs captured originally.

// File: rtl/bsrch_pkg.sv
package bsrch_pkg;
    localparam int FREQ_W = 32;
    localparam int M_BITS = 4;
    localparam int N_BITS = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_KICK,
        ST_WAIT
    } bsrch_st_e;
endpackage

// File: rtl/bsrch_serdiv.sv
// Bit-serial restoring divider: one quotient bit per cycle.
module bsrch_serdiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         valid_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          valid;
        logic [CW-1:0] cnt;
        logic [W-1:0]  den;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
    } div_s;

    div_s s_d, s_q;
    logic [W:0] shifted;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        shifted   = {s_q.rem, s_q.quo[W-1]};
        if (go_i && !s_q.run) begin
            s_d.run = 1'b1;
            s_d.cnt = CW'(W);
            s_d.den = den_i;
            s_d.quo = num_i;
            s_d.rem = '0;
        end else if (s_q.run) begin
            if (shifted >= {1'b0, s_q.den}) begin
                s_d.rem = W'(shifted - {1'b0, s_q.den});
                s_d.quo = {s_q.quo[W-2:0], 1'b1};
            end else begin
                s_d.rem = shifted[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) begin
                s_d.run   = 1'b0;
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign quot_o  = s_q.quo;
endmodule

// File: rtl/bsrch_pick.sv
// Error of one candidate and whether it displaces the current best.
module bsrch_pick #(
    parameter int W = 32
) (
    input  logic         first_i,
    input  logic [W-1:0] rate_i,
    input  logic [W-1:0] goal_i,
    input  logic [W-1:0] best_err_i,
    output logic [W-1:0] err_o,
    output logic         take_o
);
    always_comb begin
        err_o  = (rate_i >= goal_i) ? (rate_i - goal_i) : (goal_i - rate_i);
        take_o = first_i || (err_o < best_err_i);
    end
endmodule

// File: rtl/baud_div_search.sv
module baud_div_search
    import bsrch_pkg::*;
#(
    parameter int FW = bsrch_pkg::FREQ_W,
    parameter int MB = bsrch_pkg::M_BITS,
    parameter int NB = bsrch_pkg::N_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FW-1:0]     core_hz_i,
    input  logic [FW-1:0]     goal_hz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [MB+NB-1:0]  param_o
);
    localparam int PW = MB + NB;

    typedef struct packed {
        bsrch_st_e       st;
        logic [MB-1:0]   m;
        logic [NB-1:0]   n;
        logic [FW-1:0]   core;
        logic [FW-1:0]   goal;
        logic [FW-1:0]   best_err;
        logic [PW-1:0]   best;
        logic [PW-1:0]   param;
        logic            fail;
        logic            done;
    } top_s;

    top_s s_d, s_q;

    logic          div_go;
    logic          div_valid;
    logic [FW-1:0] div_quot;
    logic [FW-1:0] m_plus1;
    logic [FW-1:0] divisor;
    logic [FW-1:0] cand_err;
    logic          cand_take;
    logic          first_c;
    logic          last_c;

    // Divisor (10*(M+1)) << N from shifts and an add.
    always_comb begin
        m_plus1 = FW'(s_q.m) + FW'(1);
        divisor = ((m_plus1 << 3) + (m_plus1 << 1)) << s_q.n;
        first_c = (s_q.m == '0) && (s_q.n == '0);
        last_c  = (s_q.m == '1) && (s_q.n == '1);
        div_go  = (s_q.st == ST_KICK);
    end

    bsrch_serdiv #(.W(FW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (div_go),
        .num_i   (s_q.core),
        .den_i   (divisor),
        .valid_o (div_valid),
        .quot_o  (div_quot)
    );

    bsrch_pick #(.W(FW)) u_pick (
        .first_i    (first_c),
        .rate_i     (div_quot),
        .goal_i     (s_q.goal),
        .best_err_i (s_q.best_err),
        .err_o      (cand_err),
        .take_o     (cand_take)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (core_hz_i == '0) begin
                        s_d.done  = 1'b1;
                        s_d.fail  = 1'b1;
                        s_d.param = '0;
                    end else begin
                        s_d.st   = ST_KICK;
                        s_d.core = core_hz_i;
                        s_d.goal = goal_hz_i;
                        s_d.m    = '0;
                        s_d.n    = '0;
                    end
                end
            end
            ST_KICK: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (div_valid) begin
                    if (cand_take) begin
                        s_d.best_err = cand_err;
                        s_d.best     = {s_q.m, s_q.n};
                    end
                    if (last_c) begin
                        s_d.st    = ST_IDLE;
                        s_d.done  = 1'b1;
                        s_d.fail  = 1'b0;
                        s_d.param = cand_take ? {s_q.m, s_q.n} : s_q.best;
                    end else begin
                        s_d.st = ST_KICK;
                        s_d.m  = s_q.m + MB'(1);
                        if (s_q.m == '1) s_d.n = s_q.n + NB'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.st != ST_IDLE);
    assign done_o  = s_q.done;
    assign fail_o  = s_q.fail;
    assign param_o = s_q.param;
endmodule

// File: rtl/bsrch_chk.sv
module bsrch_chk #(
    parameter int FW = 32,
    parameter int PW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [FW-1:0] core_hz_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o,
    input logic [PW-1:0] param_o
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R5
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_hz_i != '0) |=> busy_o); // R5
    AST_ZERO_CORE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_hz_i == '0) |=> (done_o && fail_o && param_o == '0 && !busy_o)); // R6
    AST_FAIL_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> ($past(start_i) && $past(core_hz_i) == '0)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(param_o) && $stable(fail_o))); // R8
endmodule

bind baud_div_search bsrch_chk #(.FW(FW), .PW(MB + NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .core_hz_i (core_hz_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .param_o   (param_o)
);

// File: tb/tb_baud_div_search.sv
`timescale 1ns/1ps
module tb_baud_div_search;
    localparam int LAT = 128 * 34 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] core_hz_i = '0;
    logic [31:0] goal_hz_i = '0;
    logic        busy_o, done_o, fail_o;
    logic [6:0]  param_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit hung   = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_div_search dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .core_hz_i(core_hz_i), .goal_hz_i(goal_hz_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .param_o(param_o)
    );

    function automatic logic [6:0] ref_param(input longint unsigned core, input longint unsigned goal);
        longint unsigned best_e = 0;
        logic [6:0] best = '0;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                longint unsigned rate = core / ((64'(10 * (m + 1))) << n);
                longint unsigned e = (rate >= goal) ? rate - goal : goal - rate;
                if ((n == 0 && m == 0) || e < best_e) begin
                    best_e = e;
                    best   = {4'(m), 3'(n)};
                end
            end
        end
        return best;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one search; optional disturbing start at cycle poke_at (0 = none).
    task automatic run(input logic [31:0] core, input logic [31:0] goal, input int poke_at,
                       input logic [31:0] poke_core);
        int k = 0;
        bit busy_ok = 1'b1;
        logic [6:0] exp_p = ref_param(core, goal);
        @(negedge clk);
        core_hz_i = core; goal_hz_i = goal; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        check(busy_o == 1'b1, "R5 busy after start", busy_o, 1);
        while (!done_o && k < LAT + 10) begin
            if (!busy_o) busy_ok = 1'b0;
            if (poke_at != 0 && k == poke_at) begin
                core_hz_i = poke_core; goal_hz_i = ~goal; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        check(busy_ok, "R5 busy held", busy_ok, 1);
        check(k == LAT, poke_at != 0 ? "R7 R9 completion cycle" : "R9 completion cycle", k, LAT);
        check(param_o == exp_p, poke_at != 0 ? "R7 R1 R2 R3 R4 param" : "R1 R2 R3 R4 param", param_o, exp_p);
        check(fail_o == 1'b0 && busy_o == 1'b0, "R8 R5 fail clear, idle at done", {fail_o, busy_o}, 0);
        @(negedge clk);
        check(done_o == 1'b0 && param_o == exp_p, "R5 R8 one-cycle done, result held", {done_o, param_o}, {1'b0, exp_p});
    endtask

    task automatic run_zero();
        @(negedge clk);
        core_hz_i = '0; goal_hz_i = 32'd100000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && fail_o && param_o == 7'd0 && !busy_o, "R6 zero core", {done_o, fail_o, busy_o, param_o}, {3'b110, 7'd0});
        @(negedge clk);
        check(!done_o && fail_o, "R6 R8 zero core pulse, flag held", {done_o, fail_o}, 2'b01);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && fail_o == 0 && param_o == 0, "R5 reset state", {busy_o, done_o, fail_o, param_o}, 0);
        rst_n = 1'b1;
        // R3 tie: core 25, goal 0, first zero-rate pair is M=2,N=0 (0x10)
        run(32'd25, 32'd0, 0, 0);
        check(param_o == 7'h10, "R3 tie keeps earliest", param_o, 7'h10);
        // R4 packing: exact hit at M=9,N=2 gives 0x4A
        run(32'd400000000, 32'd1000000, 0, 0);
        check(param_o == 7'h4A, "R4 field packing", param_o, 7'h4A);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        run(32'd166666666, 32'd100000, 0, 0);
        run(32'd166666666, 32'd400000, 0, 0);
        run_zero();
        run(32'd200000000, 32'd100000, 2000, 32'd0);
        run(32'd50000000, 32'd3000, 300, 32'd99999999);
        run_zero();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] c = $urandom_range(32'd1000, 32'hFFFF_FFFF);
            logic [31:0] g = (i % 3 == 0) ? $urandom() : $urandom_range(32'd1, c / 10);
            run(c, g, 0, 0);
        end
        if (!hung) begin
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 190000);
        hung = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule